// File: doc/BRIEF.md
# Line-Slot FIFO Descriptor Ring

This block manages the on-chip buffer of a single DMA channel as a circular sequence of equal-sized line slots. The buffer's address range and size, the bytes per line that the transfer wants, and the base of the channel's control area are presented on a configuration port together with a one-cycle valid strobe. The block aligns the line length and works out how many whole slots fit, using a multi-cycle divider. It then reports the values a channel programmer would load: the starting pointers, the line counter value and the descriptor-table length.

At run time the block tracks which slot is in use. It presents that slot's data address and the address of the descriptor entry that points to it. Each line-complete pulse moves it to the next slot, and after the last slot it returns to the first. A combinational lookup port returns the address and the content of any descriptor entry. That lets the surrounding logic fetch the slot table without a storage array.

Top module: `lfr_line_ring`

## Requirements
- R1: The line length in use (`line_bytes`) is the requested bytes per line rounded up to the next multiple of 8. A request that is already a multiple of 8 is kept unchanged.
- R2: `slot_count` is the buffer size divided by `line_bytes`, with the remainder discarded.
- R3: `ptr_fifo_init` equals the buffer base. `ptr_cdt_init` equals the control-area base plus 64, because the descriptor table follows a 64-byte instruction queue. Both update on the edge that accepts a configuration.
- R4: `cnt_line` equals `line_bytes` divided by 8, minus 1.
- R5: `cnt_cdt` equals `slot_count` times 16, shifted right by 3 (that is, twice the slot count).
- R6: For `tbl_idx` below `slot_count`, `tbl_hit` is 1, `tbl_addr` is `ptr_cdt_init + 16*tbl_idx` and `tbl_data` is `ptr_fifo_init + tbl_idx*line_bytes`. Otherwise all three read 0.
- R7: When `cfg_busy` is low and `slot_count` is not zero, a `line_done` high at a clock edge increments `cur_idx` by one, adds `line_bytes` to `cur_slot_addr` and adds 16 to `cur_desc_addr`, all visible after that edge.
- R8: A `line_done` taken while `cur_idx` equals `slot_count-1` returns `cur_idx` to 0, `cur_slot_addr` to the buffer base and `cur_desc_addr` to the table base. `cur_idx` never reaches `slot_count`.
- R9: A rounded line length of zero, or one larger than the buffer size, sets `cfg_err`. In that case `slot_count`, `cnt_line` and `cnt_cdt` read 0, and `line_done` leaves the current-slot outputs unchanged.
- R10: A `cfg_valid` at an edge where `cfg_busy` is low is accepted. `cfg_busy` is then high for exactly 17 cycles (the size width plus one). While it is high, `cfg_valid` and `line_done` are ignored and the result outputs read 0. The final results appear on the edge at which `cfg_busy` falls, with the current slot at index 0.
- R11: After reset every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration strobe |
| cfg_fifo_base | input | 24 | Buffer start address |
| cfg_fifo_size | input | 16 | Buffer size in bytes |
| cfg_bpl | input | 16 | Requested bytes per line |
| cfg_ctrl_base | input | 24 | Channel control-area base |
| cfg_busy | output | 1 | Configuration in progress |
| cfg_err | output | 1 | Line length unusable for this buffer |
| line_bytes | output | 17 | Aligned line length |
| slot_count | output | 14 | Number of slots in the ring |
| cnt_line | output | 14 | Line counter value |
| cnt_cdt | output | 15 | Descriptor-table length value |
| ptr_fifo_init | output | 24 | Initial data pointer |
| ptr_cdt_init | output | 24 | Initial descriptor pointer (table base) |
| line_done | input | 1 | One line finished, move to the next slot |
| cur_idx | output | 14 | Current slot index |
| cur_slot_addr | output | 24 | Data address of current slot |
| cur_desc_addr | output | 24 | Descriptor address of current slot |
| tbl_idx | input | 14 | Descriptor lookup index |
| tbl_hit | output | 1 | Lookup index lies inside the ring |
| tbl_addr | output | 24 | Address of the looked-up descriptor |
| tbl_data | output | 24 | Slot address held by that descriptor |

## Verification
The assertions assume that the buffer base plus the buffer size, and the control base plus 64 plus the table length, fit in the 24-bit address space, so that no slot or descriptor address wraps. The stimulus therefore keeps bases small relative to the sizes it programs. The slot-count check also assumes that results are only judged once `cfg_busy` has fallen, which is why the stimulus sends strobes and `line_done` pulses during busy windows: those must leave no trace. Line requests cover exact multiples of 8, values just above a multiple of 8, zero, a line equal to the whole buffer, and the largest request, which rounds past the buffer size.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
    localparam int ALIGN_BYTES = 8;
    localparam int DESC_STRIDE = 16;
    localparam int IQ_BYTES    = 64;

    typedef enum logic [0:0] {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/lfr_divider.sv
module lfr_divider
    import lfr_pkg::*;
#(
    parameter int NUM_W = 16,
    parameter int DEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    div_state_e       state_q;
    logic [NUM_W-1:0] num_q;
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] steps_q;
    logic             done_q;
    logic [DEN_W:0]   trial;
    logic             take;

    always_comb begin
        trial = {rem_q, num_q[NUM_W-1]};
        take  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            num_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            steps_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                DIV_IDLE: begin
                    if (start) begin
                        state_q <= DIV_RUN;
                        num_q   <= num;
                        den_q   <= den;
                        rem_q   <= '0;
                        quo_q   <= '0;
                        steps_q <= CNT_W'(NUM_W);
                    end
                end
                DIV_RUN: begin
                    rem_q   <= take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                    quo_q   <= {quo_q[NUM_W-2:0], take};
                    num_q   <= num_q << 1;
                    steps_q <= steps_q - CNT_W'(1);
                    if (steps_q == CNT_W'(1)) begin
                        state_q <= DIV_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= DIV_IDLE;
            endcase
        end
    end

    assign busy = (state_q == DIV_RUN);
    assign done = done_q;
    assign quo  = quo_q;

    // R10: an accepted start keeps the divider running on the next cycle
    assert_start_runs_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R10: completion only follows a running cycle
    assert_done_after_run_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: rtl/lfr_ring_walker.sv
module lfr_ring_walker
    import lfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SLOT_W = 14,
    parameter int LINE_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] cdt_base,
    input  logic [LINE_W-1:0] line,
    input  logic [SLOT_W-1:0] slots,
    input  logic              step,
    output logic [SLOT_W-1:0] idx,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [ADDR_W-1:0] desc_addr
);
    logic [SLOT_W-1:0] idx_q;
    logic [ADDR_W-1:0] slot_q;
    logic [ADDR_W-1:0] desc_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cdt_q;
    logic              last;
    logic              live;

    assign last = (idx_q == slots - SLOT_W'(1));
    assign live = (slots != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q  <= '0;
            slot_q <= '0;
            desc_q <= '0;
            base_q <= '0;
            cdt_q  <= '0;
        end else if (load) begin
            idx_q  <= '0;
            slot_q <= base;
            desc_q <= cdt_base;
            base_q <= base;
            cdt_q  <= cdt_base;
        end else if (step && live) begin
            if (last) begin
                idx_q  <= '0;
                slot_q <= base_q;
                desc_q <= cdt_q;
            end else begin
                idx_q  <= idx_q + SLOT_W'(1);
                slot_q <= slot_q + ADDR_W'(line);
                desc_q <= desc_q + ADDR_W'(DESC_STRIDE);
            end
        end
    end

    assign idx       = idx_q;
    assign slot_addr = slot_q;
    assign desc_addr = desc_q;

    // R7: a step inside the ring moves one slot forward
    assert_step_advance_R7: assert property (@(posedge clk) disable iff (rst)
        (step && live && !last && !load && !clear) |=>
        (idx_q == $past(idx_q) + SLOT_W'(1)) &&
        (slot_q == $past(slot_q) + ADDR_W'($past(line))) &&
        (desc_q == $past(desc_q) + ADDR_W'(DESC_STRIDE)));
    // R8: a step on the last slot returns to slot zero
    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (step && live && last && !load && !clear) |=>
        (idx_q == '0) && (slot_q == base_q) && (desc_q == cdt_q));
    // R8: the index stays inside the ring
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (rst)
        live |-> (idx_q < slots));
endmodule

// File: rtl/lfr_desc_table.sv
module lfr_desc_table
    import lfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SLOT_W = 14,
    parameter int LINE_W = 17
) (
    input  logic [SLOT_W-1:0] idx,
    input  logic [SLOT_W-1:0] slots,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] cdt_base,
    input  logic [LINE_W-1:0] line,
    output logic              hit,
    output logic [ADDR_W-1:0] entry_addr,
    output logic [ADDR_W-1:0] entry_data
);
    logic [ADDR_W-1:0] offs_desc;
    logic [ADDR_W-1:0] offs_data;

    always_comb begin
        offs_desc  = ADDR_W'(idx) * ADDR_W'(DESC_STRIDE);
        offs_data  = ADDR_W'(idx) * ADDR_W'(line);
        hit        = (idx < slots);
        entry_addr = hit ? cdt_base + offs_desc : '0;
        entry_data = hit ? base + offs_data : '0;
    end
endmodule

// File: rtl/lfr_line_ring.sv
module lfr_line_ring
    import lfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SIZE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_valid,
    input  logic [ADDR_W-1:0]   cfg_fifo_base,
    input  logic [SIZE_W-1:0]   cfg_fifo_size,
    input  logic [SIZE_W-1:0]   cfg_bpl,
    input  logic [ADDR_W-1:0]   cfg_ctrl_base,
    output logic                cfg_busy,
    output logic                cfg_err,
    output logic [SIZE_W:0]     line_bytes,
    output logic [SIZE_W-3:0]   slot_count,
    output logic [SIZE_W-3:0]   cnt_line,
    output logic [SIZE_W-2:0]   cnt_cdt,
    output logic [ADDR_W-1:0]   ptr_fifo_init,
    output logic [ADDR_W-1:0]   ptr_cdt_init,
    input  logic                line_done,
    output logic [SIZE_W-3:0]   cur_idx,
    output logic [ADDR_W-1:0]   cur_slot_addr,
    output logic [ADDR_W-1:0]   cur_desc_addr,
    input  logic [SIZE_W-3:0]   tbl_idx,
    output logic                tbl_hit,
    output logic [ADDR_W-1:0]   tbl_addr,
    output logic [ADDR_W-1:0]   tbl_data
);
    localparam int LINE_W = SIZE_W + 1;
    localparam int SLOT_W = SIZE_W - 2;
    localparam int CNTL_W = LINE_W - 3;
    localparam int CNTD_W = SLOT_W + 1;
    localparam logic [LINE_W-1:0] ALIGN_MASK = LINE_W'(ALIGN_BYTES - 1);

    logic [LINE_W-1:0] line_rnd;
    logic              line_bad;
    logic              accept;
    logic              div_busy;
    logic              div_done;
    logic [SIZE_W-1:0] div_quo;
    logic              busy;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cdt_q;
    logic [SIZE_W-1:0] size_q;
    logic [LINE_W-1:0] pend_line_q;
    logic              pend_err_q;
    logic [LINE_W-1:0] line_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNTL_W-1:0] cntl_q;
    logic [CNTD_W-1:0] cntd_q;
    logic              err_q;
    logic [SLOT_W-1:0] slot_next;
    logic              step;

    always_comb begin
        line_rnd = ({1'b0, cfg_bpl} + ALIGN_MASK) & ~ALIGN_MASK;
        line_bad = (line_rnd == '0) || (line_rnd > {1'b0, cfg_fifo_size});
        busy     = div_busy || div_done;
        accept   = cfg_valid && !busy;
        step     = line_done && !busy && !err_q;
        slot_next = (pend_err_q || (|div_quo[SIZE_W-1:SLOT_W])) ? '0 : div_quo[SLOT_W-1:0];
    end

    lfr_divider #(
        .NUM_W (SIZE_W),
        .DEN_W (LINE_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .num   (cfg_fifo_size),
        .den   (line_rnd),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= '0;
            cdt_q       <= '0;
            size_q      <= '0;
            pend_line_q <= '0;
            pend_err_q  <= 1'b0;
            line_q      <= '0;
            slot_q      <= '0;
            cntl_q      <= '0;
            cntd_q      <= '0;
            err_q       <= 1'b0;
        end else if (accept) begin
            base_q      <= cfg_fifo_base;
            cdt_q       <= cfg_ctrl_base + ADDR_W'(IQ_BYTES);
            size_q      <= cfg_fifo_size;
            pend_line_q <= line_rnd;
            pend_err_q  <= line_bad;
            line_q      <= '0;
            slot_q      <= '0;
            cntl_q      <= '0;
            cntd_q      <= '0;
            err_q       <= 1'b0;
        end else if (div_done) begin
            line_q <= pend_line_q;
            slot_q <= slot_next;
            cntl_q <= pend_err_q ? '0 : pend_line_q[LINE_W-1:3] - CNTL_W'(1);
            cntd_q <= {slot_next, 1'b0};
            err_q  <= pend_err_q;
        end
    end

    lfr_ring_walker #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W),
        .LINE_W (LINE_W)
    ) u_walk (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .load      (div_done),
        .base      (base_q),
        .cdt_base  (cdt_q),
        .line      (pend_line_q),
        .slots     (slot_q),
        .step      (step),
        .idx       (cur_idx),
        .slot_addr (cur_slot_addr),
        .desc_addr (cur_desc_addr)
    );

    lfr_desc_table #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W),
        .LINE_W (LINE_W)
    ) u_tbl (
        .idx        (tbl_idx),
        .slots      (slot_q),
        .base       (base_q),
        .cdt_base   (cdt_q),
        .line       (line_q),
        .hit        (tbl_hit),
        .entry_addr (tbl_addr),
        .entry_data (tbl_data)
    );

    assign cfg_busy      = busy;
    assign cfg_err       = err_q;
    assign line_bytes    = line_q;
    assign slot_count    = slot_q;
    assign cnt_line      = cntl_q;
    assign cnt_cdt       = cntd_q;
    assign ptr_fifo_init = base_q;
    assign ptr_cdt_init  = cdt_q;

    // R1: the line length in use is always 8-byte aligned
    assert_line_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        line_q[2:0] == 3'b000);
    // R2: the ring fills the buffer as far as whole lines allow
    assert_slot_fit_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !err_q && slot_q != '0) |->
        ((32'(slot_q) * 32'(line_q) <= 32'(size_q)) &&
         ((32'(slot_q) + 32'd1) * 32'(line_q) > 32'(size_q))));
    // R9: a bad configuration leaves an empty ring
    assert_err_empty_R9: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (slot_q == '0) && (cntd_q == '0) && (cntl_q == '0));
    // R10: busy lasts until the divider result has been taken
    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (rst)
        div_done |=> !busy);
endmodule

// File: tb/tb_lfr_line_ring.sv
`timescale 1ns/1ps
module tb_lfr_line_ring;
    localparam int ADDR_W = 24;
    localparam int SIZE_W = 16;
    localparam int BUSY_CYC = SIZE_W + 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cfg_valid = 1'b0;
    logic [ADDR_W-1:0]   cfg_fifo_base = '0;
    logic [SIZE_W-1:0]   cfg_fifo_size = '0;
    logic [SIZE_W-1:0]   cfg_bpl = '0;
    logic [ADDR_W-1:0]   cfg_ctrl_base = '0;
    logic                cfg_busy;
    logic                cfg_err;
    logic [SIZE_W:0]     line_bytes;
    logic [SIZE_W-3:0]   slot_count;
    logic [SIZE_W-3:0]   cnt_line;
    logic [SIZE_W-2:0]   cnt_cdt;
    logic [ADDR_W-1:0]   ptr_fifo_init;
    logic [ADDR_W-1:0]   ptr_cdt_init;
    logic                line_done = 1'b0;
    logic [SIZE_W-3:0]   cur_idx;
    logic [ADDR_W-1:0]   cur_slot_addr;
    logic [ADDR_W-1:0]   cur_desc_addr;
    logic [SIZE_W-3:0]   tbl_idx = '0;
    logic                tbl_hit;
    logic [ADDR_W-1:0]   tbl_addr;
    logic [ADDR_W-1:0]   tbl_data;

    always #4 clk = ~clk;

    lfr_line_ring #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid),
        .cfg_fifo_base(cfg_fifo_base), .cfg_fifo_size(cfg_fifo_size),
        .cfg_bpl(cfg_bpl), .cfg_ctrl_base(cfg_ctrl_base),
        .cfg_busy(cfg_busy), .cfg_err(cfg_err), .line_bytes(line_bytes),
        .slot_count(slot_count), .cnt_line(cnt_line), .cnt_cdt(cnt_cdt),
        .ptr_fifo_init(ptr_fifo_init), .ptr_cdt_init(ptr_cdt_init),
        .line_done(line_done), .cur_idx(cur_idx),
        .cur_slot_addr(cur_slot_addr), .cur_desc_addr(cur_desc_addr),
        .tbl_idx(tbl_idx), .tbl_hit(tbl_hit), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data)
    );

    int checks = 0;
    int errors = 0;
    bit go = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int                m_busy = 0;
    int                m_line = 0, m_slots = 0, m_cntl = 0, m_cntd = 0, m_idx = 0;
    bit                m_err = 1'b0;
    logic [ADDR_W-1:0] m_base = '0, m_cdt = '0, m_cur = '0, m_desc = '0;
    int                p_line = 0, p_slots = 0;
    bit                p_err = 1'b0;
    int                wraps = 0;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_line = 0; m_slots = 0; m_cntl = 0; m_cntd = 0;
            m_idx = 0; m_err = 1'b0; m_base = '0; m_cdt = '0; m_cur = '0; m_desc = '0;
        end else if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) begin
                m_line  = p_line;
                m_err   = p_err;
                m_slots = p_err ? 0 : p_slots;
                m_cntl  = p_err ? 0 : p_line / 8 - 1;
                m_cntd  = (m_slots * 16) >> 3;
                m_idx   = 0;
                m_cur   = m_base;
                m_desc  = m_cdt;
            end
        end else if (cfg_valid) begin
            m_busy  = BUSY_CYC;
            m_base  = cfg_fifo_base;
            m_cdt   = cfg_ctrl_base + 64;
            p_line  = ((int'(cfg_bpl) + 7) / 8) * 8;
            p_err   = (p_line == 0) || (p_line > int'(cfg_fifo_size));
            p_slots = p_err ? 0 : int'(cfg_fifo_size) / p_line;
            m_line = 0; m_err = 1'b0; m_slots = 0; m_cntl = 0; m_cntd = 0;
            m_idx = 0; m_cur = '0; m_desc = '0;
        end else if (line_done && m_slots > 0) begin
            if (m_idx == m_slots - 1) begin
                m_idx = 0; m_cur = m_base; m_desc = m_cdt; wraps++;
            end else begin
                m_idx++;
                m_cur  = m_cur + ADDR_W'(m_line);
                m_desc = m_desc + 16;
            end
        end
    end

    always @(negedge clk) begin
        if (go && !finished) begin
            logic [ADDR_W-1:0] e_taddr, e_tdata;
            bit e_hit;
            e_hit   = int'(tbl_idx) < m_slots;
            e_taddr = e_hit ? m_cdt + ADDR_W'(int'(tbl_idx) * 16) : '0;
            e_tdata = e_hit ? m_base + ADDR_W'(int'(tbl_idx) * m_line) : '0;
            check("R10 cfg_busy", cfg_busy, (m_busy > 0));
            check("R1 line_bytes", line_bytes, m_line);
            check("R2 slot_count", slot_count, m_slots);
            check("R3 ptr_fifo_init", ptr_fifo_init, m_base);
            check("R3 ptr_cdt_init", ptr_cdt_init, m_cdt);
            check("R4 cnt_line", cnt_line, m_cntl);
            check("R5 cnt_cdt", cnt_cdt, m_cntd);
            check("R9 cfg_err", cfg_err, m_err);
            check("R7 R8 cur_idx", cur_idx, m_idx);
            check("R7 R8 cur_slot_addr", cur_slot_addr, m_cur);
            check("R7 R8 cur_desc_addr", cur_desc_addr, m_desc);
            check("R6 tbl_hit", tbl_hit, e_hit);
            check("R6 tbl_addr", tbl_addr, e_taddr);
            check("R6 tbl_data", tbl_data, e_tdata);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic run(input int n, input int done_pct, input int idx_max);
        for (int i = 0; i < n; i++) begin
            line_done = ($urandom_range(0, 99) < done_pct);
            tbl_idx   = (SIZE_W-2)'($urandom_range(0, idx_max));
            tick();
        end
        line_done = 1'b0;
    endtask

    task automatic configure(input int base, input int size, input int bpl,
                             input int ctrl, input bit poke);
        cfg_fifo_base = ADDR_W'(base);
        cfg_fifo_size = SIZE_W'(size);
        cfg_bpl       = SIZE_W'(bpl);
        cfg_ctrl_base = ADDR_W'(ctrl);
        cfg_valid     = 1'b1;
        tick();
        cfg_valid = 1'b0;
        // R10: strobe with other values while busy must be ignored
        if (poke) begin
            cfg_fifo_size = 16'h0040;
            cfg_bpl       = 16'h0008;
            cfg_valid     = 1'b1;
            tick();
            cfg_valid = 1'b0;
        end
        run(BUSY_CYC + 2, 50, 40);
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        // R11: reset values
        check("R11 cfg_busy", cfg_busy, 0);
        check("R11 slot_count", slot_count, 0);
        check("R11 line_bytes", line_bytes, 0);
        check("R11 cur_slot_addr", cur_slot_addr, 0);
        check("R11 ptr_cdt_init", ptr_cdt_init, 0);
        check("R11 tbl_hit", tbl_hit, 0);
        rst = 1'b0;
        go  = 1'b1;
        tick();

        // aligned line: 2048 / 128 = 16 slots, walk past the end
        configure(32'h001000, 32'h0800, 128, 32'h000400, 1'b1);
        run(40, 100, 20);
        run(60, 40, 20);

        // unaligned request: 100 -> 104, 10240 / 104 = 98
        configure(32'h003400, 32'h2800, 100, 32'h0004a0, 1'b0);
        run(300, 70, 110);

        // line fills the buffer exactly: one slot, always wraps onto itself
        configure(32'h000200, 32'h0200, 32'h01fc, 32'h000080, 1'b0);
        run(12, 100, 3);

        // line longer than buffer: error, ring empty (R9)
        configure(32'h000800, 32'h0800, 32'h0900, 32'h000100, 1'b0);
        run(12, 100, 5);

        // zero request: error (R9)
        configure(32'h000900, 32'h0400, 0, 32'h000100, 1'b1);
        run(8, 100, 5);

        // largest request rounds past 16 bits: error (R1, R9)
        configure(32'h000000, 32'hffff, 32'hffff, 32'h000000, 1'b0);
        run(8, 100, 5);

        // smallest line: 65535 / 8 = 8191 slots
        configure(32'h010000, 32'hffff, 1, 32'h000040, 1'b0);
        run(200, 60, 9000);

        // back to a short ring to exercise wrap again after reconfiguration
        configure(32'h000100, 32'h0030, 9, 32'h000000, 1'b1);
        run(30, 100, 4);

        check("R8 wrap events seen", (wraps > 3), 1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule